// File: doc/BRIEF.md
# Home Directory Controller

This block holds the global coherence bookkeeping for memory lines whose home is the local node. For each line it tracks a global state (free, shared or exclusive) and a 64-bit vector with one bit per node that holds a copy. It runs a migratory policy: every read miss, even a plain read, takes the line away from its current holders. The current owner is told to forward the line directly to the requester, so the data never passes through the home node. The requester then acknowledges, and the directory records it as the sole exclusive holder.

Requests and acknowledgements share one input port. Coherence messages leave on one output port, which always accepts them. Directory metadata lives outside the block behind a cache. The block issues tagged lookups and accepts responses after any latency and in any order, for example a short one on a hit and a long one on a miss. A fixed pool of transaction slots lets several lines be in flight at once. Each line may occupy at most one slot. A requester on the home node itself follows the same path, and messages bound for the home node are flagged so that they stay off the network.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset the block accepts reads (`req_ready_o` high), and drives no message, no metadata lookup and no metadata write.
- R2: An accepted read (`req_kind_i` = 0) starts a metadata lookup for its line. Until that line's transaction has written back its metadata, a read to the same line is not accepted.
- R3: Up to NSLOT (default 4) reads to distinct lines are in progress together. While all slots are busy, `req_ready_o` is low for reads.
- R4: If the looked-up state is free (code 0), the block sends no invalidation. It sends one home-data message (type 1) to the requester, then writes state exclusive (code 2) with only the requester's bit set.
- R5: If the state is shared (1) or exclusive (2), the block sends one message to each holder other than the requester, in ascending node order. The first is invalidate-and-forward (type 2), the rest are plain invalidates (type 3), and each carries the requester's id in `msg_req_o`.
- R6: The requester is never invalidated. When the requester is the only holder, the line is served as in R4.
- R7: After the requester's acknowledgement (`req_kind_i` = 1) for a line waiting on it, the block writes state exclusive with the requester's bit as the only bit set, and frees the slot.
- R8: An acknowledgement for a line with no waiting transaction, or from a node other than that line's requester, is ignored: it causes no metadata write and no message.
- R9: `msg_local_o` is high with a message exactly when its destination is the home node (HOME_NODE, default 0).
- R10: Metadata responses may return out of order. Each response is applied to the transaction named by its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request or acknowledgement present |
| req_kind_i | input | 1 | 0 read miss, 1 acknowledgement |
| req_node_i | input | 6 | Requesting node id |
| req_line_i | input | 8 | Line index (page and line within page) |
| req_ready_o | output | 1 | Request accepted this cycle |
| msg_valid_o | output | 1 | Outgoing coherence message |
| msg_type_o | output | 2 | 1 home data, 2 invalidate and forward, 3 invalidate |
| msg_dst_o | output | 6 | Destination node |
| msg_req_o | output | 6 | Node that requested the line |
| msg_line_o | output | 8 | Line index |
| msg_local_o | output | 1 | Destination is the home node |
| md_rd_valid_o | output | 1 | Metadata lookup request |
| md_rd_tag_o | output | 2 | Transaction tag of the lookup |
| md_rd_line_o | output | 8 | Line to look up |
| md_rsp_valid_i | input | 1 | Metadata response |
| md_rsp_tag_i | input | 2 | Tag of the response |
| md_rsp_state_i | input | 2 | Line state: 0 free, 1 shared, 2 exclusive |
| md_rsp_sharers_i | input | 64 | Holder vector, bit n for node n |
| md_wr_valid_o | output | 1 | Metadata write |
| md_wr_line_o | output | 8 | Line to write |
| md_wr_state_o | output | 2 | New state |
| md_wr_sharers_o | output | 64 | New holder vector |

## Verification
The hardest situation to reach is several transactions in flight at once whose metadata responses come back in a different order than their lookups were issued. Two other cases sit inside that same window: a second read to a busy line, and a read arriving while every slot is taken. The bench acts as the metadata cache and gives lines with an odd index a longer latency than even ones. It then accepts four reads on consecutive lines back to back, so the slow lookup for an earlier line returns after the fast one for a later line. While those four are still waiting for acknowledgements, it offers a same-line read and a fifth-line read and expects both to be refused.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  typedef enum logic [1:0] {ST_FREE = 2'd0, ST_SHARED = 2'd1, ST_EXCL = 2'd2} dir_state_e;
  typedef enum logic [1:0] {
    MSG_NONE = 2'd0, MSG_HOME_DATA = 2'd1, MSG_INV_FWD = 2'd2, MSG_INV = 2'd3
  } msg_e;
  typedef enum logic [2:0] {SL_IDLE, SL_RD, SL_WAIT, SL_SEND, SL_ACK, SL_WB} slot_e;
  localparam logic REQ_READ = 1'b0;
  localparam logic REQ_ACK  = 1'b1;
endpackage

// File: rtl/hdc_arb.sv
module hdc_arb #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // fixed priority, lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    gnt_o = any_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/hdc_slot.sv
module hdc_slot
  import hdc_pkg::*;
#(
  parameter int NODES  = 64,
  parameter int NODE_W = 6,
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [NODE_W-1:0] alloc_node_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              rsp_i,
  input  logic [1:0]        rsp_state_i,
  input  logic [NODES-1:0]  rsp_sharers_i,
  input  logic              ack_i,
  input  logic [NODE_W-1:0] ack_node_i,
  input  logic [LINE_W-1:0] ack_line_i,
  input  logic              rd_gnt_i,
  input  logic              msg_gnt_i,
  input  logic              wr_gnt_i,
  output logic              busy_o,
  output logic [LINE_W-1:0] line_o,
  output logic [NODE_W-1:0] node_o,
  output logic              rd_req_o,
  output logic              msg_req_o,
  output logic [1:0]        msg_type_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic              wr_req_o
);
  slot_e             st_q;
  logic [LINE_W-1:0] line_q;
  logic [NODE_W-1:0] node_q;
  logic [NODES-1:0]  pend_q, pend_nx, self_bit, others;
  logic              first_q, home_q;

  assign self_bit = NODES'(1) << node_q;
  assign others   = rsp_sharers_i & ~self_bit;

  always_comb begin
    msg_dst_o = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend_q[i]) msg_dst_o = NODE_W'(i);
    end
    pend_nx = pend_q & ~(NODES'(1) << msg_dst_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SL_IDLE;
      line_q  <= '0;
      node_q  <= '0;
      pend_q  <= '0;
      first_q <= 1'b0;
      home_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SL_IDLE: if (alloc_i) begin
          line_q <= alloc_line_i;
          node_q <= alloc_node_i;
          st_q   <= SL_RD;
        end
        SL_RD: if (rd_gnt_i) st_q <= SL_WAIT;
        SL_WAIT: if (rsp_i) begin
          first_q <= 1'b1;
          st_q    <= SL_SEND;
          if (rsp_state_i == ST_FREE || others == '0) begin
            pend_q <= self_bit;
            home_q <= 1'b1;
          end else begin
            pend_q <= others;
            home_q <= 1'b0;
          end
        end
        SL_SEND: if (msg_gnt_i) begin
          pend_q  <= pend_nx;
          first_q <= 1'b0;
          if (pend_nx == '0) st_q <= home_q ? SL_WB : SL_ACK;
        end
        SL_ACK: if (ack_i && ack_line_i == line_q && ack_node_i == node_q) st_q <= SL_WB;
        SL_WB: if (wr_gnt_i) st_q <= SL_IDLE;
        default: st_q <= SL_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != SL_IDLE);
  assign line_o     = line_q;
  assign node_o     = node_q;
  assign rd_req_o   = (st_q == SL_RD);
  assign msg_req_o  = (st_q == SL_SEND);
  assign wr_req_o   = (st_q == SL_WB);
  assign msg_type_o = home_q ? MSG_HOME_DATA : (first_q ? MSG_INV_FWD : MSG_INV);
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdc_pkg::*;
#(
  parameter  int NSLOT          = 4,
  parameter  int NODES          = 64,
  parameter  int PAGE_W         = 3,
  parameter  int LINES_PER_PAGE = 32,
  parameter  int HOME_NODE      = 0,
  localparam int NODE_W         = $clog2(NODES),
  localparam int LINE_W         = PAGE_W + $clog2(LINES_PER_PAGE),
  localparam int TAG_W          = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              req_ready_o,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [NODE_W-1:0] msg_req_o,
  output logic [LINE_W-1:0] msg_line_o,
  output logic              msg_local_o,
  output logic              md_rd_valid_o,
  output logic [TAG_W-1:0]  md_rd_tag_o,
  output logic [LINE_W-1:0] md_rd_line_o,
  input  logic              md_rsp_valid_i,
  input  logic [TAG_W-1:0]  md_rsp_tag_i,
  input  logic [1:0]        md_rsp_state_i,
  input  logic [NODES-1:0]  md_rsp_sharers_i,
  output logic              md_wr_valid_o,
  output logic [LINE_W-1:0] md_wr_line_o,
  output logic [1:0]        md_wr_state_o,
  output logic [NODES-1:0]  md_wr_sharers_o
);
  logic [NSLOT-1:0]  busy, rd_req, msg_req, wr_req;
  logic [NSLOT-1:0]  free_gnt, rd_gnt, msg_gnt, wr_gnt, alloc_vec;
  logic [TAG_W-1:0]  free_idx, rd_idx, msg_idx, wr_idx;
  logic              free_any, rd_any, msg_any, wr_any, line_hit, is_read, is_ack;
  logic [LINE_W-1:0] s_line [NSLOT];
  logic [NODE_W-1:0] s_node [NSLOT];
  logic [NODE_W-1:0] s_dst  [NSLOT];
  logic [1:0]        s_type [NSLOT];

  assign is_read = req_valid_i && (req_kind_i == REQ_READ);
  assign is_ack  = req_valid_i && (req_kind_i == REQ_ACK);

  always_comb begin
    line_hit = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (busy[i] && s_line[i] == req_line_i) line_hit = 1'b1;
    end
  end

  assign req_ready_o = (req_kind_i == REQ_ACK) ? 1'b1 : (free_any && !line_hit);
  assign alloc_vec   = (is_read && req_ready_o) ? free_gnt : '0;

  hdc_arb #(.N(NSLOT), .IDX_W(TAG_W)) i_free_arb (
    .req_i(~busy), .gnt_o(free_gnt), .idx_o(free_idx), .any_o(free_any));
  hdc_arb #(.N(NSLOT), .IDX_W(TAG_W)) i_rd_arb (
    .req_i(rd_req), .gnt_o(rd_gnt), .idx_o(rd_idx), .any_o(rd_any));
  hdc_arb #(.N(NSLOT), .IDX_W(TAG_W)) i_msg_arb (
    .req_i(msg_req), .gnt_o(msg_gnt), .idx_o(msg_idx), .any_o(msg_any));
  hdc_arb #(.N(NSLOT), .IDX_W(TAG_W)) i_wr_arb (
    .req_i(wr_req), .gnt_o(wr_gnt), .idx_o(wr_idx), .any_o(wr_any));

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    hdc_slot #(.NODES(NODES), .NODE_W(NODE_W), .LINE_W(LINE_W)) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc_vec[g]),
      .alloc_node_i (req_node_i),
      .alloc_line_i (req_line_i),
      .rsp_i        (md_rsp_valid_i && md_rsp_tag_i == TAG_W'(g)),
      .rsp_state_i  (md_rsp_state_i),
      .rsp_sharers_i(md_rsp_sharers_i),
      .ack_i        (is_ack),
      .ack_node_i   (req_node_i),
      .ack_line_i   (req_line_i),
      .rd_gnt_i     (rd_gnt[g]),
      .msg_gnt_i    (msg_gnt[g]),
      .wr_gnt_i     (wr_gnt[g]),
      .busy_o       (busy[g]),
      .line_o       (s_line[g]),
      .node_o       (s_node[g]),
      .rd_req_o     (rd_req[g]),
      .msg_req_o    (msg_req[g]),
      .msg_type_o   (s_type[g]),
      .msg_dst_o    (s_dst[g]),
      .wr_req_o     (wr_req[g])
    );
  end

  assign md_rd_valid_o   = rd_any;
  assign md_rd_tag_o     = rd_idx;
  assign md_rd_line_o    = s_line[rd_idx];

  assign msg_valid_o     = msg_any;
  assign msg_type_o      = msg_any ? s_type[msg_idx] : MSG_NONE;
  assign msg_dst_o       = s_dst[msg_idx];
  assign msg_req_o       = s_node[msg_idx];
  assign msg_line_o      = s_line[msg_idx];
  assign msg_local_o     = msg_any && (s_dst[msg_idx] == NODE_W'(HOME_NODE));

  assign md_wr_valid_o   = wr_any;
  assign md_wr_line_o    = s_line[wr_idx];
  assign md_wr_state_o   = ST_EXCL;
  assign md_wr_sharers_o = NODES'(1) << s_node[wr_idx];
endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter  int NSLOT          = 4,
  parameter  int NODES          = 64,
  parameter  int PAGE_W         = 3,
  parameter  int LINES_PER_PAGE = 32,
  localparam int NODE_W         = $clog2(NODES),
  localparam int LINE_W         = PAGE_W + $clog2(LINES_PER_PAGE),
  localparam int TAG_W          = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_kind_i,
  input logic [LINE_W-1:0] req_line_i,
  input logic              req_ready_o,
  input logic              msg_valid_o,
  input logic [1:0]        msg_type_o,
  input logic [NODE_W-1:0] msg_dst_o,
  input logic [NODE_W-1:0] msg_req_o,
  input logic              md_wr_valid_o,
  input logic [1:0]        md_wr_state_o,
  input logic [NODES-1:0]  md_wr_sharers_o
);
  logic [TAG_W:0] open_cnt;
  logic           rd_acc;

  assign rd_acc = req_valid_i && (req_kind_i == 1'b0) && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_cnt <= '0;
    else open_cnt <= open_cnt + (TAG_W+1)'(rd_acc) - (TAG_W+1)'(md_wr_valid_o);
  end

  a_r2_line_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> (!(req_valid_i && req_kind_i == 1'b0 && req_line_i == $past(req_line_i))
                || !req_ready_o));

  a_r3_slot_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_cnt == (TAG_W+1)'(NSLOT)) |-> !rd_acc);

  a_r4_wr_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_wr_valid_o |-> (md_wr_state_o == 2'd2 && $countones(md_wr_sharers_o) == 1));

  a_r6_no_self_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o != 2'd1) |-> (msg_dst_o != msg_req_o));

  a_r7_wr_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_wr_valid_o |-> (open_cnt != '0));
endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(
  .NSLOT(NSLOT), .NODES(NODES), .PAGE_W(PAGE_W), .LINES_PER_PAGE(LINES_PER_PAGE)
) i_chk (.*);

// File: tb/test_home_dir_ctrl.sv
module test_home_dir_ctrl;
  localparam int NW = 6, LW = 8, TW = 2, NL = 256;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_kind_i = 1'b0;
  logic [NW-1:0] req_node_i = '0;
  logic [LW-1:0] req_line_i = '0;
  logic          req_ready_o, msg_valid_o, msg_local_o, md_rd_valid_o, md_wr_valid_o;
  logic [1:0]    msg_type_o, md_wr_state_o;
  logic [NW-1:0] msg_dst_o, msg_req_o;
  logic [LW-1:0] msg_line_o, md_rd_line_o, md_wr_line_o;
  logic [TW-1:0] md_rd_tag_o;
  logic          md_rsp_valid_i = 1'b0;
  logic [TW-1:0] md_rsp_tag_i = '0;
  logic [1:0]    md_rsp_state_i = '0;
  logic [63:0]   md_rsp_sharers_i = '0, md_wr_sharers_o;

  home_dir_ctrl i_home_dir_ctrl (.*);

  always #2 clk_i = ~clk_i;

  int    vectors = 0, misses = 0, cyc = 0;
  bit    finished = 0;
  bit [1:0]  mem_st [NL];
  bit [63:0] mem_sh [NL];
  int    req_of [NL];
  bit    busy [NL], resp_done [NL], exp_wr [NL];
  int    resp_cyc [NL];
  int    eq [NL][$];
  int    p_tag [$], p_line [$], p_due [$];

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // reference directory, metadata cache model and output comparison
  always @(negedge clk_i) begin
    cyc++;
    md_rsp_valid_i = 1'b0;
    if (rst_ni) begin
      if (msg_valid_o) begin
        int l, got;
        l   = int'(msg_line_o);
        got = (int'(msg_type_o) << 12) | (int'(msg_dst_o) << 6) | int'(msg_req_o);
        if (eq[l].size() == 0) chk(0, "R5", "unexpected message", got, 0);
        else begin
          int e;
          e = eq[l].pop_front();
          chk(got == e, "R5", "message type/dst/req", got, e);
        end
        chk(msg_local_o == (msg_dst_o == 6'd0), "R9", "local flag", msg_local_o, msg_dst_o == 6'd0);
      end
      if (md_wr_valid_o) begin
        int l;
        l = int'(md_wr_line_o);
        if (!exp_wr[l]) chk(0, "R8", "unexpected metadata write", l, 0);
        else begin
          chk(md_wr_state_o == 2'd2, "R7", "write state", md_wr_state_o, 2);
          chk(md_wr_sharers_o == (64'd1 << req_of[l]), "R7", "write holders",
              md_wr_sharers_o, 64'd1 << req_of[l]);
          mem_st[l] = md_wr_state_o;
          mem_sh[l] = md_wr_sharers_o;
          exp_wr[l] = 0;
          busy[l]   = 0;
        end
      end
      if (md_rd_valid_o) begin
        p_tag.push_back(int'(md_rd_tag_o));
        p_line.push_back(int'(md_rd_line_o));
        p_due.push_back(cyc + (md_rd_line_o[0] ? 12 : 4));
      end
      for (int k = 0; k < p_due.size(); k++) begin
        if (p_due[k] <= cyc) begin
          int l, q;
          bit [63:0] oth;
          bit first;
          l = p_line[k];
          q = req_of[l];
          md_rsp_valid_i   = 1'b1;
          md_rsp_tag_i     = TW'(p_tag[k]);
          md_rsp_state_i   = mem_st[l];
          md_rsp_sharers_i = mem_sh[l];
          oth = mem_sh[l] & ~(64'd1 << q);
          if (mem_st[l] == 2'd0 || oth == 0) begin
            eq[l].push_back((1 << 12) | (q << 6) | q);
            exp_wr[l] = 1;
          end else begin
            first = 1;
            for (int n = 0; n < 64; n++) begin
              if (oth[n]) begin
                eq[l].push_back(((first ? 2 : 3) << 12) | (n << 6) | q);
                first = 0;
              end
            end
          end
          resp_done[l] = 1;
          resp_cyc[l]  = cyc;
          p_tag.delete(k); p_line.delete(k); p_due.delete(k);
          break;
        end
      end
    end
  end

  task automatic accept(int node, int line);
    req_of[line] = node; busy[line] = 1; resp_done[line] = 0;
  endtask

  task automatic rd(int node, int line);
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = 0; req_node_i = NW'(node); req_line_i = LW'(line);
    #1;
    while (!req_ready_o) begin @(negedge clk_i); #1; end
    accept(node, line);
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic try_rd(int node, int line, bit exp_rdy, string r);
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = 0; req_node_i = NW'(node); req_line_i = LW'(line);
    #1;
    chk(req_ready_o == exp_rdy, r, "read acceptance", req_ready_o, exp_rdy);
    if (req_ready_o && exp_rdy) begin
      accept(node, line);
      @(negedge clk_i);
    end
    req_valid_i = 0;
  endtask

  task automatic ack(int node, int line, bit counts);
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = 1; req_node_i = NW'(node); req_line_i = LW'(line);
    if (counts) exp_wr[line] = 1;
    @(negedge clk_i);
    req_valid_i = 0; req_kind_i = 0;
  endtask

  task automatic wait_msgs(int line);
    while (!(resp_done[line] && eq[line].size() == 0)) @(negedge clk_i);
  endtask

  task automatic wait_idle(int line);
    while (busy[line]) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "WATCHDOG", "run did not complete", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      mem_st[i] = 0; mem_sh[i] = 0; busy[i] = 0; exp_wr[i] = 0; resp_done[i] = 0;
    end
    mem_st[3] = 2; mem_sh[3] = 64'd1 << 9;
    mem_st[5] = 1; mem_sh[5] = (64'd1 << 1) | (64'd1 << 7) | (64'd1 << 40) | (64'd1 << 63);
    mem_st[6] = 2; mem_sh[6] = 64'd1 << 12;
    mem_st[7] = 2; mem_sh[7] = 64'd1;
    for (int i = 10; i < 14; i++) begin mem_st[i] = 2; mem_sh[i] = 64'd1 << (i + 10); end

    repeat (3) @(negedge clk_i);
    #1;
    chk(req_ready_o == 1, "R1", "ready after reset", req_ready_o, 1);
    chk(msg_valid_o == 0, "R1", "no message in reset", msg_valid_o, 0);
    chk(md_rd_valid_o == 0 && md_wr_valid_o == 0, "R1", "no metadata traffic in reset",
        {md_rd_valid_o, md_wr_valid_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(req_ready_o == 1 && !msg_valid_o && !md_rd_valid_o && !md_wr_valid_o, "R1",
        "idle after reset release", {req_ready_o, msg_valid_o, md_rd_valid_o, md_wr_valid_o}, 4'b1000);

    // R4 free lines, remote and home requester
    rd(5, 2); wait_idle(2);
    chk(mem_st[2] == 2 && mem_sh[2] == (64'd1 << 5), "R4", "free line now owned", mem_sh[2], 64'd1 << 5);
    rd(0, 4); wait_idle(4);

    // R5 exclusive owner forwards; R8 stray acks ignored
    rd(4, 3); wait_msgs(3);
    ack(5, 3, 0);
    ack(4, 20, 0);
    repeat (10) @(negedge clk_i);
    chk(busy[3] == 1, "R8", "line still waits after stray acks", busy[3], 1);
    chk(mem_sh[3] == (64'd1 << 9), "R8", "holders unchanged by stray acks", mem_sh[3], 64'd1 << 9);
    ack(4, 3, 1); wait_idle(3);
    chk(mem_sh[3] == (64'd1 << 4), "R7", "requester sole owner", mem_sh[3], 64'd1 << 4);

    // R5/R6 shared line, requester among holders
    rd(7, 5); wait_msgs(5); ack(7, 5, 1); wait_idle(5);
    chk(mem_st[5] == 2 && mem_sh[5] == (64'd1 << 7), "R7", "shared line migrated", mem_sh[5], 64'd1 << 7);

    // R6 requester is the only holder
    rd(12, 6); wait_idle(6);

    // R9 owner is the home node
    rd(30, 7); wait_msgs(7); ack(30, 7, 1); wait_idle(7);

    // reuse a line: new owner gets invalidated
    rd(9, 3); wait_msgs(3); ack(9, 3, 1); wait_idle(3);
    chk(mem_sh[3] == (64'd1 << 9), "R7", "line returned to node 9", mem_sh[3], 64'd1 << 9);

    // R2/R3/R10 concurrency
    try_rd(1, 10, 1, "R3");
    try_rd(8, 10, 0, "R2");
    try_rd(2, 11, 1, "R3");
    try_rd(3, 12, 1, "R3");
    try_rd(4, 13, 1, "R3");
    try_rd(6, 14, 0, "R3");
    for (int i = 10; i < 14; i++) wait_msgs(i);
    chk(resp_cyc[11] > resp_cyc[12], "R10", "slow lookup answered after fast one",
        resp_cyc[11], resp_cyc[12]);
    for (int i = 10; i < 14; i++) ack(i - 9, i, 1);
    for (int i = 10; i < 14; i++) wait_idle(i);
    for (int i = 10; i < 14; i++)
      chk(mem_sh[i] == (64'd1 << (i - 9)), "R10", "each line owned by its requester",
          mem_sh[i], 64'd1 << (i - 9));
    try_rd(6, 14, 1, "R3");
    wait_idle(14);

    repeat (20) @(negedge clk_i);
    begin
      int left;
      left = p_due.size();
      for (int i = 0; i < NL; i++) left += eq[i].size() + int'(exp_wr[i]);
      chk(left == 0, "R5", "all expected traffic seen", left, 0);
    end
    finish_run();
  end
endmodule